// File: doc/BRIEF.md
# Video Sync Reference Port Controller

This block manages two bidirectional timing reference pins at the edge of a video encoder. Each pin is set up on its own. As an output, it drives a registered timing pulse taken from the internal raster counters. As an input, it is synchronized, and an edge on it is turned into a single-cycle sync event for the encoder core. The first pin carries vertical timing: a per-field vertical sync, an odd/even frame flag, or a field-sequence pulse that appears only on every fourth or eighth field. The second pin carries line timing. As an output, it gives a line-active reference or a video-active reference. As an input, it can act as the horizontal sync source and can also act as an external blanking signal.

No data stream passes through the block. Every pin is a plain control or timing level, so there is no valid/ready handshake and no back-pressure.

Configuration bits are sampled on every clock edge. A change is therefore seen at the next edge, and each output pulse moves by at most one clock.

Top module: `sref_port_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after release, `ref_out`, `ref_oe`, `hs_evt`, `vs_evt` and `blank` are all 0.
- R2: `ref_oe[i]` equals the value `cfg_dir[i]` had one clock earlier (1 = output, 0 = input). While a pin is an input, its `ref_out` bit is 0 one clock later.
- R3: On an output pin, `ref_out[i]` is the pin's functional level from the previous clock, XORed with `cfg_pol[i]`. A polarity of 0 means active high and 1 means active low.
- R4: On pin 0 as an output, `cfg_p1_type` selects the functional level. Code 0 gives `tm_vs`. Code 1 gives the odd-field flag `tm_odd`. Code 3 gives a constant inactive level.
- R5: With `cfg_p1_type` = 2 (field sequence), pin 0 gives `tm_vs` only in a matching field. When `cfg_fseq4` = 1, a field matches if `tm_fcnt[1:0]` = 0. When `cfg_fseq4` = 0, a field matches only if `tm_fcnt` = 0.
- R6: On pin 1 as an output, `cfg_p2_mode` = 0 gives `tm_hact`. `cfg_p2_mode` = 1 gives `tm_hact & tm_vact`, which stays low during vertical blanking.
- R7: On an input pin, the edge selected by `cfg_pol` (rising for 0, falling for 1) gives one single-cycle event. It appears on the third clock edge after the pin changes. The opposite edge gives no event.
- R8: `hs_evt` follows the input events of pin 0 when `cfg_hsrc_sel` = 0 and those of pin 1 when `cfg_hsrc_sel` = 1.
- R9: `vs_evt` follows the input events of pin 0 as follows. It is always passed for type codes 0 and 1. For code 2 it is passed only in a field that matches as in R5. For code 3 it is never passed.
- R10: `blank` is 1 only when all of these hold: pin 1 is an input, `cfg_hsrc_sel` = 1, `cfg_p2_mode` = 1, and pin 1's synchronized level is inactive for its polarity.
- R11: After reset, no edge event is produced until the synchronizer has held two consecutive equal real samples. A pin that is held active through reset therefore raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pol | input | 2 | Per-pin polarity / capture edge select |
| cfg_dir | input | 2 | Per-pin direction, 1 = output |
| cfg_p1_type | input | 2 | Pin 0 signal type code |
| cfg_fseq4 | input | 1 | Field-sequence period: 1 = every 4th field, 0 = every 8th |
| cfg_p2_mode | input | 1 | Pin 1 mode: video-active reference / blanking input |
| cfg_hsrc_sel | input | 1 | Horizontal sync source: 0 = pin 0, 1 = pin 1 |
| tm_vs | input | 1 | Raster vertical sync level |
| tm_odd | input | 1 | Raster odd-field flag |
| tm_fcnt | input | 3 | Raster field counter, 0 to 7 |
| tm_hact | input | 1 | Active part of the line, every line |
| tm_vact | input | 1 | Active (non-blanking) line |
| ref_in | input | 2 | Pin receive values |
| ref_out | output | 2 | Pin drive values |
| ref_oe | output | 2 | Pin output enables |
| hs_evt | output | 1 | Horizontal sync event, one cycle |
| vs_evt | output | 1 | Vertical sync event, one cycle |
| blank | output | 1 | External blanking indication |

## Verification
The bound checker watches several relations on every cycle. Output enables follow the direction bits one cycle later. Input pins drive low. Pin 1's output matches its reference formula. The inactive type code gives neither a pin pulse nor a vertical event. Non-matching fields never give a field-sequence event. `blank` stays low unless its enabling conditions held. Some behaviour only the directed scenarios can show: the exact three-edge event latency, the choice of capture edge by polarity, the switching of the horizontal source, and the suppression of events during the arming window after reset.

// File: rtl/sref_pkg.sv
package sref_pkg;
  localparam int NPIN   = 2;
  localparam int FCNT_W = 3;

  typedef enum logic [1:0] {
    P1_VSYNC = 2'd0,
    P1_FRAME = 2'd1,
    P1_FSEQ  = 2'd2,
    P1_NONE  = 2'd3
  } p1_type_e;

  // field-sequence match: every fourth or every eighth field
  function automatic logic field_hit(input logic [FCNT_W-1:0] fcnt, input logic every4);
    field_hit = every4 ? (fcnt[1:0] == 2'b00) : (fcnt == '0);
  endfunction
endpackage

// File: rtl/sref_in_sync.sv
module sref_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic pol_i,
  input  logic en_i,
  output logic edge_o,
  output logic level_o,
  output logic armed_o
);
  localparam int CNT_MAX = STAGES + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [STAGES:0] chain;
  logic [CNT_W-1:0] fill_q;
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= pin_i;
  end

  for (genvar k = 1; k <= STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[k] <= 1'b0;
      else        chain[k] <= chain[k-1];
    end
  end

  logic cur_n, prev_n;
  assign cur_n  = chain[STAGES-1] ^ pol_i;
  assign prev_n = chain[STAGES] ^ pol_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      if (fill_q != CNT_W'(CNT_MAX)) fill_q <= fill_q + 1'b1;
      if (fill_q == CNT_W'(CNT_MAX) && chain[STAGES-1] == chain[STAGES])
        armed_q <= 1'b1;
    end
  end

  assign edge_o  = armed_q & en_i & cur_n & ~prev_n;
  assign level_o = cur_n;
  assign armed_o = armed_q;
endmodule

// File: rtl/sref_out_drv.sv
module sref_out_drv (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_i,
  input  logic pol_i,
  input  logic func_i,
  output logic out_o,
  output logic oe_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_o <= 1'b0;
      oe_o  <= 1'b0;
    end else begin
      out_o <= dir_i ? (func_i ^ pol_i) : 1'b0;
      oe_o  <= dir_i;
    end
  end
endmodule

// File: rtl/sref_port_ctrl.sv
module sref_port_ctrl
  import sref_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   cfg_pol,
  input  logic [NPIN-1:0]   cfg_dir,
  input  logic [1:0]        cfg_p1_type,
  input  logic              cfg_fseq4,
  input  logic              cfg_p2_mode,
  input  logic              cfg_hsrc_sel,
  input  logic              tm_vs,
  input  logic              tm_odd,
  input  logic [FCNT_W-1:0] tm_fcnt,
  input  logic              tm_hact,
  input  logic              tm_vact,
  input  logic [NPIN-1:0]   ref_in,
  output logic [NPIN-1:0]   ref_out,
  output logic [NPIN-1:0]   ref_oe,
  output logic              hs_evt,
  output logic              vs_evt,
  output logic              blank
);
  logic [NPIN-1:0] in_edge, in_level, in_armed, func_lvl;
  logic fld_ok, vs_pass;
  p1_type_e p1_type;

  assign p1_type = p1_type_e'(cfg_p1_type);
  assign fld_ok  = field_hit(tm_fcnt, cfg_fseq4);

  always_comb begin
    unique case (p1_type)
      P1_VSYNC: begin func_lvl[0] = tm_vs;          vs_pass = 1'b1;   end
      P1_FRAME: begin func_lvl[0] = tm_odd;         vs_pass = 1'b1;   end
      P1_FSEQ:  begin func_lvl[0] = tm_vs & fld_ok; vs_pass = fld_ok; end
      default:  begin func_lvl[0] = 1'b0;           vs_pass = 1'b0;   end
    endcase
  end

  assign func_lvl[1] = tm_hact & (~cfg_p2_mode | tm_vact);

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    sref_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_i   (ref_in[i]),
      .pol_i   (cfg_pol[i]),
      .en_i    (~cfg_dir[i]),
      .edge_o  (in_edge[i]),
      .level_o (in_level[i]),
      .armed_o (in_armed[i])
    );
    sref_out_drv u_drv (
      .clk    (clk),
      .rst_n  (rst_n),
      .dir_i  (cfg_dir[i]),
      .pol_i  (cfg_pol[i]),
      .func_i (func_lvl[i]),
      .out_o  (ref_out[i]),
      .oe_o   (ref_oe[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_evt <= 1'b0;
      vs_evt <= 1'b0;
      blank  <= 1'b0;
    end else begin
      hs_evt <= cfg_hsrc_sel ? in_edge[1] : in_edge[0];
      vs_evt <= in_edge[0] & vs_pass;
      blank  <= ~cfg_dir[1] & cfg_hsrc_sel & cfg_p2_mode & in_armed[1] & ~in_level[1];
    end
  end
endmodule

// File: rtl/sref_chk.sv
module sref_chk
  import sref_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NPIN-1:0]   cfg_pol,
  input logic [NPIN-1:0]   cfg_dir,
  input logic [1:0]        cfg_p1_type,
  input logic              cfg_fseq4,
  input logic              cfg_p2_mode,
  input logic              cfg_hsrc_sel,
  input logic [FCNT_W-1:0] tm_fcnt,
  input logic              tm_hact,
  input logic              tm_vact,
  input logic [NPIN-1:0]   ref_out,
  input logic [NPIN-1:0]   ref_oe,
  input logic              hs_evt,
  input logic              vs_evt,
  input logic              blank
);
  p_oe_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ref_oe == $past(cfg_dir));

  p_idle0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_dir[0] |=> !ref_out[0]);

  p_idle1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_dir[1] |=> !ref_out[1]);

  p_p2_ref_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_dir[1] |=> ref_out[1] ==
      ($past(tm_hact & (!cfg_p2_mode | tm_vact)) ^ $past(cfg_pol[1])));

  p_p1_none_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dir[0] && cfg_p1_type == 2'd3) |=> ref_out[0] == $past(cfg_pol[0]));

  p_vs_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_p1_type == 2'd3) |=> !vs_evt);

  p_vs_field_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_p1_type == 2'd2 &&
     !(cfg_fseq4 ? (tm_fcnt[1:0] == 2'b00) : (tm_fcnt == '0))) |=> !vs_evt);

  p_blank_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cfg_dir[1] && cfg_hsrc_sel && cfg_p2_mode) |=> !blank);

  p_out_no_evt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dir == 2'b11) |=> (!hs_evt && !vs_evt));
endmodule

bind sref_port_ctrl sref_chk u_sref_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_pol      (cfg_pol),
  .cfg_dir      (cfg_dir),
  .cfg_p1_type  (cfg_p1_type),
  .cfg_fseq4    (cfg_fseq4),
  .cfg_p2_mode  (cfg_p2_mode),
  .cfg_hsrc_sel (cfg_hsrc_sel),
  .tm_fcnt      (tm_fcnt),
  .tm_hact      (tm_hact),
  .tm_vact      (tm_vact),
  .ref_out      (ref_out),
  .ref_oe       (ref_oe),
  .hs_evt       (hs_evt),
  .vs_evt       (vs_evt),
  .blank        (blank)
);

// File: tb/sref_port_ctrl_tb_top.sv
module sref_port_ctrl_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_pol = '0, cfg_dir = '0, cfg_p1_type = '0;
  logic       cfg_fseq4 = 1'b0, cfg_p2_mode = 1'b0, cfg_hsrc_sel = 1'b0;
  logic       tm_vs = 1'b0, tm_odd = 1'b0, tm_hact = 1'b0, tm_vact = 1'b0;
  logic [2:0] tm_fcnt = '0;
  logic [1:0] ref_in = '0;
  logic [1:0] ref_out, ref_oe;
  logic       hs_evt, vs_evt, blank;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  sref_port_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_pol(cfg_pol), .cfg_dir(cfg_dir),
    .cfg_p1_type(cfg_p1_type), .cfg_fseq4(cfg_fseq4), .cfg_p2_mode(cfg_p2_mode),
    .cfg_hsrc_sel(cfg_hsrc_sel), .tm_vs(tm_vs), .tm_odd(tm_odd), .tm_fcnt(tm_fcnt),
    .tm_hact(tm_hact), .tm_vact(tm_vact), .ref_in(ref_in), .ref_out(ref_out),
    .ref_oe(ref_oe), .hs_evt(hs_evt), .vs_evt(vs_evt), .blank(blank)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic [1:0] pins);
    rst_n = 1'b0;
    cfg_pol = '0; cfg_dir = '0; cfg_p1_type = '0; cfg_fseq4 = 1'b0;
    cfg_p2_mode = 1'b0; cfg_hsrc_sel = 1'b0; tm_fcnt = '0;
    tm_vs = 1'b0; tm_odd = 1'b0; tm_hact = 1'b0; tm_vact = 1'b0;
    ref_in = pins;
    tick(3);
    rst_n = 1'b1;
  endtask

  // set pin level, then count events over a window
  task automatic drive_count(input int idx, input logic v, output int nh, output int nv);
    ref_in[idx] = v;
    nh = 0; nv = 0;
    for (int k = 0; k < 6; k++) begin
      tick(1);
      nh += int'(hs_evt);
      nv += int'(vs_evt);
    end
  endtask

  task automatic t_reset();
    do_reset(2'b00);
    rst_n = 1'b0;
    tick(1);
    chk("R1 reset out", ref_out, 0);
    chk("R1 reset oe", ref_oe, 0);
    chk("R1 reset evts", {hs_evt, vs_evt, blank}, 0);
    rst_n = 1'b1;
    tick(1);
    chk("R1 after release", {ref_out, ref_oe, hs_evt, vs_evt, blank}, 0);
  endtask

  task automatic t_dir();
    do_reset(2'b00);
    tick(2);
    tm_vs = 1'b1; tm_hact = 1'b1;
    cfg_dir = 2'b01;
    tick(1);
    chk("R2 oe follows dir", ref_oe, 1);
    chk("R2 input pin drives low", ref_out[1], 0);
    cfg_dir = 2'b10;
    tick(1);
    chk("R2 oe switch", ref_oe, 2);
    chk("R2 pin0 now low", ref_out[0], 0);
  endtask

  task automatic t_p1_types();
    do_reset(2'b00);
    cfg_dir = 2'b01;
    cfg_p1_type = 2'd0; tm_vs = 1'b1; tm_odd = 1'b0;
    tick(1);
    chk("R4 vsync type high", ref_out[0], 1);
    tm_vs = 1'b0;
    tick(1);
    chk("R4 vsync type low", ref_out[0], 0);
    cfg_pol[0] = 1'b1;
    tick(1);
    chk("R3 active-low idle", ref_out[0], 1);
    cfg_pol[0] = 1'b0;
    cfg_p1_type = 2'd1; tm_odd = 1'b1;
    tick(1);
    chk("R4 frame type odd", ref_out[0], 1);
    tm_odd = 1'b0;
    tick(1);
    chk("R4 frame type even", ref_out[0], 0);
    cfg_p1_type = 2'd3; tm_vs = 1'b1; tm_odd = 1'b1;
    tick(1);
    chk("R4 n/a type inactive", ref_out[0], 0);
    cfg_pol[0] = 1'b1;
    tick(1);
    chk("R3 n/a type inactive low-pol", ref_out[0], 1);
  endtask

  task automatic t_fseq();
    do_reset(2'b00);
    cfg_dir = 2'b01; cfg_p1_type = 2'd2; tm_vs = 1'b1;
    cfg_fseq4 = 1'b1; tm_fcnt = 3'd4;
    tick(1);
    chk("R5 every4 field4", ref_out[0], 1);
    cfg_fseq4 = 1'b0;
    tick(1);
    chk("R5 every8 field4", ref_out[0], 0);
    tm_fcnt = 3'd0;
    tick(1);
    chk("R5 every8 field0", ref_out[0], 1);
    cfg_fseq4 = 1'b1; tm_fcnt = 3'd2;
    tick(1);
    chk("R5 every4 field2", ref_out[0], 0);
  endtask

  task automatic t_p2_out();
    do_reset(2'b00);
    cfg_dir = 2'b10; cfg_p2_mode = 1'b0;
    tm_hact = 1'b1; tm_vact = 1'b0;
    tick(1);
    chk("R6 line ref in vblank", ref_out[1], 1);
    cfg_p2_mode = 1'b1;
    tick(1);
    chk("R6 video ref in vblank", ref_out[1], 0);
    tm_vact = 1'b1;
    tick(1);
    chk("R6 video ref active", ref_out[1], 1);
    cfg_pol[1] = 1'b1;
    tick(1);
    chk("R3 pin1 active-low", ref_out[1], 0);
  endtask

  task automatic t_in_edge();
    int nh, nv;
    do_reset(2'b00);
    tick(8);
    ref_in[0] = 1'b1;
    tick(2);
    chk("R7 no event before third edge", hs_evt, 0);
    tick(1);
    chk("R7 event at third edge", hs_evt, 1);
    tick(1);
    chk("R7 event single cycle", hs_evt, 0);
    drive_count(0, 1'b0, nh, nv);
    chk("R7 falling ignored pol0", nh, 0);
    cfg_pol[0] = 1'b1;
    tick(4);
    drive_count(0, 1'b1, nh, nv);
    chk("R7 rising ignored pol1", nh, 0);
    drive_count(0, 1'b0, nh, nv);
    chk("R7 falling taken pol1", nh, 1);
    chk("R9 vs follows pin0 type0", nv, 1);
  endtask

  task automatic t_hsrc();
    int nh, nv;
    do_reset(2'b00);
    cfg_hsrc_sel = 1'b1;
    tick(8);
    drive_count(1, 1'b1, nh, nv);
    chk("R8 hs from pin1", nh, 1);
    chk("R8 pin1 no vs", nv, 0);
    drive_count(0, 1'b1, nh, nv);
    chk("R8 pin0 ignored for hs", nh, 0);
    chk("R9 vs still from pin0", nv, 1);
  endtask

  task automatic t_vs_gate();
    int nh, nv;
    do_reset(2'b00);
    tick(8);
    cfg_p1_type = 2'd3;
    drive_count(0, 1'b1, nh, nv);
    chk("R9 n/a type no vs", nv, 0);
    drive_count(0, 1'b0, nh, nv);
    cfg_p1_type = 2'd2; cfg_fseq4 = 1'b0; tm_fcnt = 3'd4;
    drive_count(0, 1'b1, nh, nv);
    chk("R9 every8 field4 rejected", nv, 0);
    drive_count(0, 1'b0, nh, nv);
    cfg_fseq4 = 1'b1;
    drive_count(0, 1'b1, nh, nv);
    chk("R9 every4 field4 accepted", nv, 1);
    drive_count(0, 1'b0, nh, nv);
    cfg_fseq4 = 1'b0; tm_fcnt = 3'd0;
    drive_count(0, 1'b1, nh, nv);
    chk("R9 every8 field0 accepted", nv, 1);
  endtask

  task automatic t_blank();
    do_reset(2'b10);
    cfg_hsrc_sel = 1'b1; cfg_p2_mode = 1'b1;
    tick(8);
    chk("R10 pin1 active no blank", blank, 0);
    ref_in[1] = 1'b0;
    tick(5);
    chk("R10 pin1 inactive blank", blank, 1);
    cfg_p2_mode = 1'b0;
    tick(1);
    chk("R10 mode0 no blank", blank, 0);
    cfg_p2_mode = 1'b1; cfg_hsrc_sel = 1'b0;
    tick(1);
    chk("R10 src pin0 no blank", blank, 0);
  endtask

  task automatic t_arm();
    int nh, nv;
    do_reset(2'b01);
    nh = 0;
    for (int k = 0; k < 10; k++) begin
      tick(1);
      nh += int'(hs_evt);
    end
    chk("R11 held-high pin no event", nh, 0);
    drive_count(0, 1'b0, nh, nv);
    drive_count(0, 1'b1, nh, nv);
    chk("R11 edge after arming", nh, 1);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_dir();
    t_p1_types();
    t_fseq();
    t_p2_out();
    t_in_edge();
    t_hsrc();
    t_vs_gate();
    t_blank();
    t_arm();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule